// File: doc/BRIEF.md
# Reset Sequencer with Source Selection

This block runs the reset sequence of a microcontroller. Six requests can start it: power-on, low supply voltage, a low level on the shared reset pin, a bus access to an unmapped address, a clock-monitor fault and a watchdog expiry. The clock-monitor request counts only while the monitor enable is set. The watchdog request counts only while its 3-bit rate field is nonzero. Once started, the block pulls the open-drain reset pin low for `DRIVE_CYCLES` clocks and then lets go. It waits `SETTLE_CYCLES` more clocks and reads the pin back through a synchronizer.

If the pin still reads low, an outside agent is holding the board in reset, and the common vector class is chosen. If the pin reads high, the choice follows the fault flags latched during the sequence. A pending clock-monitor fault takes priority over a pending watchdog fault. With neither flag pending, the common class is chosen.

The choice is placed on a 2-bit code, together with a one-cycle strobe. The internal system reset stays active from detection until that strobe. A new request that arrives before the strobe starts the pin drive again from the beginning.

Top module: `rstseq_top`

## Requirements
- R1: If `sys_rst_o` is low and any of `por_req_i`, `lvr_req_i` or `ill_addr_req_i` is high at a clock edge, `rst_pin_drive_o` and `sys_rst_o` are high in the next cycle. A low level on `rst_pin_i` that lasts for more than `SYNC_STAGES` cycles while the block is idle also starts a sequence.
- R2: Without further requests, `rst_pin_drive_o` stays high for exactly `DRIVE_CYCLES` consecutive cycles.
- R3: `vec_valid_o` rises exactly `SETTLE_CYCLES` cycles after the first cycle in which `rst_pin_drive_o` is low.
- R4: If the synchronized pin reads low in the last settle cycle, `vec_sel_o` is 2'b00 (common), whatever faults are pending.
- R5: If the pin reads high and a clock-monitor fault is pending, `vec_sel_o` is 2'b01, even when a watchdog fault is also pending. The code 2'b11 never appears with the strobe.
- R6: If the pin reads high, no clock-monitor fault is pending and a watchdog fault is pending, `vec_sel_o` is 2'b10.
- R7: If the pin reads high and no fault is pending, `vec_sel_o` is 2'b00.
- R8: `clkmon_fail_i` starts a sequence and latches a fault only while `osc_mon_en_i` is 1. `wdog_timeout_i` does so only while `wdog_rate_i` is nonzero. When disabled, neither one drives the pin nor changes the later vector.
- R9: A power-on, low-voltage or illegal-address request during the drive or settle phase restarts the drive phase from its first cycle, and no strobe follows in the next cycle.
- R10: Latched faults survive a restart and are cleared when the strobe is issued, so the next sequence with no faults yields 2'b00.
- R11: `sys_rst_o` is high whenever `rst_pin_drive_o` is high. It stays high until the strobe cycle and is low in the strobe cycle. `vec_valid_o` lasts exactly one cycle.
- R12: While `rst_ni` is low, the pin drive and the system reset are both high and there is no strobe. The sequence that follows reset release lasts `DRIVE_CYCLES` drive cycles, counting the cycle in which reset is released, and ends with 2'b00.
- R13: A low level on `rst_pin_i` during the settle phase that has cleared the synchronizer by the last settle cycle neither restarts the sequence nor changes the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reset-domain clock |
| rst_ni | input | 1 | Asynchronous active-low register reset |
| por_req_i | input | 1 | Power-on request |
| lvr_req_i | input | 1 | Low-voltage request |
| ill_addr_req_i | input | 1 | Illegal-address request |
| clkmon_fail_i | input | 1 | Clock-monitor fault |
| osc_mon_en_i | input | 1 | Enable for the clock-monitor source |
| wdog_timeout_i | input | 1 | Watchdog expiry |
| wdog_rate_i | input | RATE_W | Watchdog rate field; zero disables the source |
| rst_pin_i | input | 1 | Level read back from the reset pin |
| rst_pin_drive_o | output | 1 | Pulls the open-drain pin low when high |
| sys_rst_o | output | 1 | Internal system reset |
| vec_sel_o | output | 2 | Vector class: 00 common, 01 clock monitor, 10 watchdog |
| vec_valid_o | output | 1 | One-cycle strobe marking `vec_sel_o` as valid |

## Verification
The checker watches several properties on every cycle. It checks the minimum drive length and the exact settle gap before each strobe, using run counters. It checks that the three unconditional sources and the enabled fault sources start a drive phase. It checks that these requests restart the sequence while it is in flight, and it checks the shape of the strobe and of the system reset.

The vector decision needs the pin level and the latched faults, and so do the gating of disabled sources and the clearing of flags after a strobe. Only the bench's scenarios show these. It sweeps every combination of fault, enable, rate and held pin, checks restarts in each phase, and checks a short pin glitch during settling.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DRIVE  = 2'd1,
    ST_SETTLE = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    VEC_COMMON = 2'b00,
    VEC_CLKMON = 2'b01,
    VEC_WDOG   = 2'b10
  } vec_sel_e;

  // Pin read back low means an outside agent still holds reset.
  function automatic vec_sel_e pick_vector(input logic pin_high,
                                           input logic clkmon_pend,
                                           input logic wdog_pend);
    vec_sel_e v;
    if (!pin_high)        v = VEC_COMMON;
    else if (clkmon_pend) v = VEC_CLKMON;
    else if (wdog_pend)   v = VEC_WDOG;
    else                  v = VEC_COMMON;
    return v;
  endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_req.sv
module rstseq_req #(
  parameter int RATE_W = 3
) (
  input  logic              por_i,
  input  logic              lvr_i,
  input  logic              ill_addr_i,
  input  logic              clkmon_fail_i,
  input  logic              osc_mon_en_i,
  input  logic              wdog_timeout_i,
  input  logic [RATE_W-1:0] wdog_rate_i,
  input  logic              pin_sync_i,
  input  logic              idle_i,
  output logic              clkmon_hit_o,
  output logic              wdog_hit_o,
  output logic              restart_o
);

  logic wdog_armed;
  logic pin_req;

  always_comb begin
    wdog_armed   = |wdog_rate_i;
    clkmon_hit_o = clkmon_fail_i & osc_mon_en_i;
    wdog_hit_o   = wdog_timeout_i & wdog_armed;
    // The pin is its own output during a sequence, so it counts only when idle.
    pin_req      = idle_i & ~pin_sync_i;
    restart_o    = por_i | lvr_i | ill_addr_i | clkmon_hit_o | wdog_hit_o | pin_req;
  end

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int DRIVE_CYCLES  = 512,
  parameter int SETTLE_CYCLES = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       clkmon_hit_i,
  input  logic       wdog_hit_i,
  input  logic       pin_sync_i,
  output logic       idle_o,
  output logic       pin_drive_o,
  output logic       sys_rst_o,
  output logic [1:0] vec_o,
  output logic       vec_valid_o
);

  localparam int MAX_CYC = (DRIVE_CYCLES > SETTLE_CYCLES) ? DRIVE_CYCLES : SETTLE_CYCLES;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] DRIVE_LAST  = CNT_W'(DRIVE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clkmon_pend_q, clkmon_pend_d;
  logic             wdog_pend_q, wdog_pend_d;
  vec_sel_e         vec_q, vec_d;
  logic             valid_q, valid_d;
  logic             vec_load;

  always_comb begin
    state_d       = state_q;
    cnt_d         = cnt_q;
    clkmon_pend_d = clkmon_pend_q | clkmon_hit_i;
    wdog_pend_d   = wdog_pend_q | wdog_hit_i;
    vec_d         = vec_q;
    valid_d       = 1'b0;
    vec_load      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (restart_i) begin
          state_d = ST_DRIVE;
          cnt_d   = '0;
        end
      end
      ST_DRIVE: begin
        if (restart_i) begin
          cnt_d = '0;
        end else if (cnt_q == DRIVE_LAST) begin
          state_d = ST_SETTLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SETTLE: begin
        if (restart_i) begin
          state_d = ST_DRIVE;
          cnt_d   = '0;
        end else if (cnt_q == SETTLE_LAST) begin
          state_d       = ST_IDLE;
          cnt_d         = '0;
          vec_d         = pick_vector(pin_sync_i, clkmon_pend_q, wdog_pend_q);
          vec_load      = 1'b1;
          valid_d       = 1'b1;
          clkmon_pend_d = 1'b0;
          wdog_pend_d   = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_DRIVE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_DRIVE;
      cnt_q         <= '0;
      clkmon_pend_q <= 1'b0;
      wdog_pend_q   <= 1'b0;
      valid_q       <= 1'b0;
    end else begin
      state_q       <= state_d;
      cnt_q         <= cnt_d;
      clkmon_pend_q <= clkmon_pend_d;
      wdog_pend_q   <= wdog_pend_d;
      valid_q       <= valid_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       vec_q <= VEC_COMMON;
    else if (vec_load) vec_q <= vec_d;
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign pin_drive_o = (state_q == ST_DRIVE);
  assign sys_rst_o   = (state_q != ST_IDLE);
  assign vec_o       = vec_q;
  assign vec_valid_o = valid_q;

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
  parameter int DRIVE_CYCLES  = 512,
  parameter int SETTLE_CYCLES = 256,
  parameter int SYNC_STAGES   = 2,
  parameter int RATE_W        = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_req_i,
  input  logic              lvr_req_i,
  input  logic              ill_addr_req_i,
  input  logic              clkmon_fail_i,
  input  logic              osc_mon_en_i,
  input  logic              wdog_timeout_i,
  input  logic [RATE_W-1:0] wdog_rate_i,
  input  logic              rst_pin_i,
  output logic              rst_pin_drive_o,
  output logic              sys_rst_o,
  output logic [1:0]        vec_sel_o,
  output logic              vec_valid_o
);

  logic pin_sync;
  logic idle;
  logic clkmon_hit;
  logic wdog_hit;
  logic restart;

  rstseq_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rst_pin_i),
    .q_o   (pin_sync)
  );

  rstseq_req #(
    .RATE_W(RATE_W)
  ) u_req (
    .por_i         (por_req_i),
    .lvr_i         (lvr_req_i),
    .ill_addr_i    (ill_addr_req_i),
    .clkmon_fail_i (clkmon_fail_i),
    .osc_mon_en_i  (osc_mon_en_i),
    .wdog_timeout_i(wdog_timeout_i),
    .wdog_rate_i   (wdog_rate_i),
    .pin_sync_i    (pin_sync),
    .idle_i        (idle),
    .clkmon_hit_o  (clkmon_hit),
    .wdog_hit_o    (wdog_hit),
    .restart_o     (restart)
  );

  rstseq_fsm #(
    .DRIVE_CYCLES (DRIVE_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart),
    .clkmon_hit_i(clkmon_hit),
    .wdog_hit_i  (wdog_hit),
    .pin_sync_i  (pin_sync),
    .idle_o      (idle),
    .pin_drive_o (rst_pin_drive_o),
    .sys_rst_o   (sys_rst_o),
    .vec_o       (vec_sel_o),
    .vec_valid_o (vec_valid_o)
  );

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int DRIVE_CYCLES  = 512,
  parameter int SETTLE_CYCLES = 256,
  parameter int RATE_W        = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_req_i,
  input logic              lvr_req_i,
  input logic              ill_addr_req_i,
  input logic              clkmon_fail_i,
  input logic              osc_mon_en_i,
  input logic              wdog_timeout_i,
  input logic [RATE_W-1:0] wdog_rate_i,
  input logic              rst_pin_drive_o,
  input logic              sys_rst_o,
  input logic [1:0]        vec_sel_o,
  input logic              vec_valid_o
);

  localparam int MAX_CYC = (DRIVE_CYCLES > SETTLE_CYCLES) ? DRIVE_CYCLES : SETTLE_CYCLES;
  localparam int CW      = $clog2(MAX_CYC + 2) + 1;
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  logic [CW-1:0] run_q;
  logic [CW-1:0] gap_q;
  logic          hard_req;

  assign hard_req = por_req_i | lvr_req_i | ill_addr_req_i;

  // Length of the current drive run and of the current released run.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      gap_q <= '0;
    end else begin
      if (rst_pin_drive_o) begin
        run_q <= (run_q == SAT) ? run_q : run_q + 1'b1;
        gap_q <= '0;
      end else begin
        run_q <= '0;
        gap_q <= (gap_q == SAT) ? gap_q : gap_q + 1'b1;
      end
    end
  end

  p_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && hard_req) |=> (rst_pin_drive_o && sys_rst_o));

  p_drive_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_pin_drive_o) |-> (run_q >= CW'(DRIVE_CYCLES)));

  p_settle_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (gap_q == CW'(SETTLE_CYCLES)));

  p_vec_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_sel_o != 2'b11));

  p_clkmon_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && clkmon_fail_i && osc_mon_en_i) |=> rst_pin_drive_o);

  p_wdog_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && wdog_timeout_i && (|wdog_rate_i)) |=> rst_pin_drive_o);

  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && hard_req) |=> (rst_pin_drive_o && !vec_valid_o));

  p_strobe_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o);

  p_strobe_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> !sys_rst_o);

  p_drive_in_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pin_drive_o |-> sys_rst_o);

  p_rst_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> vec_valid_o);

endmodule

bind rstseq_top rstseq_chk #(
  .DRIVE_CYCLES (DRIVE_CYCLES),
  .SETTLE_CYCLES(SETTLE_CYCLES),
  .RATE_W       (RATE_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .por_req_i      (por_req_i),
  .lvr_req_i      (lvr_req_i),
  .ill_addr_req_i (ill_addr_req_i),
  .clkmon_fail_i  (clkmon_fail_i),
  .osc_mon_en_i   (osc_mon_en_i),
  .wdog_timeout_i (wdog_timeout_i),
  .wdog_rate_i    (wdog_rate_i),
  .rst_pin_drive_o(rst_pin_drive_o),
  .sys_rst_o      (sys_rst_o),
  .vec_sel_o      (vec_sel_o),
  .vec_valid_o    (vec_valid_o)
);

// File: tb/rstseq_top_tb_top.sv
module rstseq_top_tb_top;

  localparam int D  = 8;
  localparam int W  = 6;
  localparam int RW = 3;

  logic          clk;
  logic          rst_n;
  logic          por, lvr, ill, clkf, osc_en, wdog;
  logic [RW-1:0] rate;
  logic          ext_level;
  logic          hold_ext;
  logic          pin;
  logic          drive, sys_rst, vvalid;
  logic [1:0]    vsel;

  int n_chk;
  int n_fail;

  assign pin = drive ? 1'b0 : ext_level;

  rstseq_top #(
    .DRIVE_CYCLES (D),
    .SETTLE_CYCLES(W),
    .SYNC_STAGES  (2),
    .RATE_W       (RW)
  ) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .por_req_i      (por),
    .lvr_req_i      (lvr),
    .ill_addr_req_i (ill),
    .clkmon_fail_i  (clkf),
    .osc_mon_en_i   (osc_en),
    .wdog_timeout_i (wdog),
    .wdog_rate_i    (rate),
    .rst_pin_i      (pin),
    .rst_pin_drive_o(drive),
    .sys_rst_o      (sys_rst),
    .vec_sel_o      (vsel),
    .vec_valid_o    (vvalid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Follows a started sequence to its strobe. inj_t pulses lvr, ext_t pulls the pin low
  // for one cycle, both at cycle t counted from the first cycle after the start.
  task automatic measure(input int inj_t, input int ext_t,
                         output int drv, output int gap, output int vec, output int rst_ok);
    drv = 0; gap = 0; vec = -1; rst_ok = 1;
    for (int t = 1; t < 2000; t++) begin
      @(negedge clk);
      por = 0; ill = 0; clkf = 0; wdog = 0;
      if (vvalid) begin
        vec = int'(vsel);
        if (sys_rst) rst_ok = 0;
        lvr = 0;
        ext_level = !hold_ext;
        break;
      end
      if (!sys_rst) rst_ok = 0;
      if (drive) begin drv++; gap = 0; end
      else gap++;
      lvr = (t == inj_t);
      ext_level = !(hold_ext || (t == ext_t));
    end
  endtask

  // Lets follow-on sequences (from a pin still read low) finish; they must give 00.
  task automatic settle_quiet();
    int d, g, v, ok;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (sys_rst) begin
        measure(-1, -1, d, g, v, ok);
        check_eq("R10 follow-on vector after flags cleared", v, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int d, g, v, ok, seen, exp;
    n_chk = 0; n_fail = 0;
    por = 0; lvr = 0; ill = 0; clkf = 0; osc_en = 0; wdog = 0; rate = '0;
    ext_level = 1; hold_ext = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check_eq("R12 drive in reset", int'(drive), 1);
    check_eq("R12 sys_rst in reset", int'(sys_rst), 1);
    check_eq("R12 no strobe in reset", int'(vvalid), 0);
    rst_n = 1;
    measure(-1, -1, d, g, v, ok);
    check_eq("R12 drive after reset (release cycle counted apart)", d, D - 1);
    check_eq("R12 settle after reset", g, W);
    check_eq("R12 vector after reset", v, 0);
    settle_quiet();

    // R8 disabled sources do nothing
    @(negedge clk);
    osc_en = 0; clkf = 1; rate = 0; wdog = 1;
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      clkf = 0; wdog = 0;
      if (drive || sys_rst) seen = 1;
    end
    check_eq("R8 disabled faults start nothing", seen, 0);
    ill = 1;
    measure(-1, -1, d, g, v, ok);
    check_eq("R8 disabled faults leave no flag", v, 0);
    settle_quiet();

    // R1 each plain source starts a sequence
    @(negedge clk); por = 1;
    measure(-1, -1, d, g, v, ok);
    check_eq("R1 power-on start drive", d, D);
    check_eq("R1 power-on vector", v, 0);
    settle_quiet();
    @(negedge clk); lvr = 1;
    measure(-1, -1, d, g, v, ok);
    check_eq("R1 low-voltage start drive", d, D);
    settle_quiet();
    @(negedge clk); ext_level = 0;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      ext_level = 1;
      if (drive) begin seen = 1; break; end
    end
    check_eq("R1 pin low in idle starts sequence", seen, 1);
    measure(-1, -1, d, g, v, ok);
    check_eq("R1 pin-started vector", v, 0);
    settle_quiet();

    // R9 restart in drive phase, R10 flag survives restart
    @(negedge clk); osc_en = 0; rate = 3'd1; wdog = 1;
    measure(5, -1, d, g, v, ok);
    check_eq("R9 drive restart length", d, 5 + D);
    check_eq("R10 watchdog flag kept across restart", v, 2);
    settle_quiet();
    @(negedge clk); ill = 1;
    measure(-1, -1, d, g, v, ok);
    check_eq("R10 flags cleared after strobe", v, 0);
    settle_quiet();

    // R9 restart in settle phase
    @(negedge clk); ill = 1;
    measure(D + 2, -1, d, g, v, ok);
    check_eq("R9 settle restart drive total", d, 2 * D);
    check_eq("R9 settle restart final gap", g, W);
    settle_quiet();

    // R13 pin glitch in settle phase
    @(negedge clk); ill = 1;
    measure(-1, D + 1, d, g, v, ok);
    check_eq("R13 glitch no restart", d, D);
    check_eq("R13 glitch gap", g, W);
    check_eq("R13 glitch vector", v, 0);
    settle_quiet();

    // Sweep: faults, enable, rate, held pin -> R2 R3 R4 R5 R6 R7 R11
    for (int c = 0; c < 2; c++)
      for (int e = 0; e < 2; e++)
        for (int w = 0; w < 2; w++)
          for (int r = 0; r < 8; r++)
            for (int h = 0; h < 2; h++) begin
              @(negedge clk);
              ill = 1; clkf = c[0]; osc_en = e[0]; wdog = w[0]; rate = r[RW-1:0];
              hold_ext = h[0]; ext_level = !h[0];
              measure(-1, -1, d, g, v, ok);
              if (h != 0) exp = 0;                 // R4
              else if (c != 0 && e != 0) exp = 1;  // R5
              else if (w != 0 && r != 0) exp = 2;  // R6
              else exp = 0;                        // R7
              check_eq("R2 drive length", d, D);
              check_eq("R3 settle gap", g, W);
              check_eq("R4/R5/R6/R7 vector", v, exp);
              check_eq("R11 sys_rst until strobe", ok, 1);
              hold_ext = 0; ext_level = 1;
              settle_quiet();
            end

    summary();
  end

endmodule